// File: doc/BRIEF.md
# T1 Remote Alarm Detector

This block watches a received T1 stream for the remote (yellow) alarm and drives one alarm flag. A mode input picks one of two detection rules. With the superframe rule (mode 0), the block takes received DS0 channel bytes, each tagged with its channel index, and a strobe that closes each frame. A frame counts as "alarming" when every channel carried a 0 in its second bit. The flag rises after a long run of such frames and falls only after a long run of frames that are not alarming. This makes the superframe rule robust against scattered line errors.

With the extended superframe rule (mode 1), the block takes the facility data link one bit at a time under a valid strobe. The flag is up exactly while the last sixteen link bits form eight zeros followed by eight ones. The flag does not tolerate errors, so a single wrong bit drops it at once. Any downstream integration is left to the system. Only the detector chosen by the mode runs. The other one is held cleared, so a change of mode restarts detection from nothing.

Top module: `t1_yellow_det`

## Requirements
- R1: A synchronous active-high reset clears both detectors and drives `alarm_o` low.
- R2: In mode 0 a frame is alarming when, since the previous `frm_strobe_i`, a byte arrived for every index 0 to NUM_CH-1 (default 24), and each such byte had bit 6 (the second bit received, MSB first) equal to 0. Indices of NUM_CH or above are ignored. A byte presented in the same cycle as the strobe belongs to the next frame.
- R3: In mode 0 `alarm_o` rises at the strobe that completes SET_FRAMES (default 4800) consecutive alarming frames. It is visible one clock after that strobe.
- R4: In mode 0 a frame that is not alarming, seen before the alarm is set, restarts the set count from zero.
- R5: In mode 0 an active alarm falls at the strobe that completes REL_FRAMES (default 1600) consecutive frames that are not alarming. Any alarming frame restarts that count, so scattered bad frames never clear the alarm.
- R6: In mode 0 a frame in which any channel index below NUM_CH is missing is not alarming.
- R7: In mode 1 `alarm_o` goes high one clock after a valid link bit with which the last 16 valid bits, oldest first, are 0x00FF. At least 16 bits must have arrived since the last clear.
- R8: In mode 1 `alarm_o` holds while `fdl_valid_i` is low. It falls one clock after the next valid bit that breaks the pattern.
- R9: A change of `mode_i` clears detector state: the newly selected detector starts from its cleared state, and `alarm_o` is low right after the switch.
- R10: Channel inputs have no effect in mode 1, and link inputs have no effect in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | 0 = superframe rule, 1 = extended superframe rule |
| ch_valid_i | input | 1 | Channel byte valid |
| ch_idx_i | input | CH_IDX_W | Channel index of the byte |
| ch_byte_i | input | 8 | Received channel byte, MSB received first |
| frm_strobe_i | input | 1 | Closes the current received frame |
| fdl_valid_i | input | 1 | Link bit valid |
| fdl_bit_i | input | 1 | Received facility data link bit |
| alarm_o | output | 1 | Remote alarm indication |

## Verification
In the superframe rule the bench sends runs of all-clear frames that are cut short by one bad frame. It also sends frames with a single set bit, frames with a missing channel, and frames with out-of-range indices that carry set bits. These patterns show the set and release thresholds, which frames restart each count, and which frames are alarming. For the link rule the bench sends the exact code word and a code word with one flipped bit. It also sends a short run of ones just after a clear and idle gaps after a match, which separate the fill rule, the hold rule and the drop on a breaking bit. Mode switches while an alarm is up, and stimulus sent to the inactive side, show clearing and isolation.

// File: rtl/t1ya_pkg.sv
package t1ya_pkg;
   typedef enum logic {
      RULE_SF  = 1'b0,
      RULE_ESF = 1'b1
   } rule_e;

   localparam int unsigned BYTE_W      = 8;
   localparam int unsigned ALARM_BIT   = 6;   // second bit received, MSB first
   localparam int unsigned CODE_W      = 16;
   localparam logic [15:0] CODE_WORD   = 16'h00FF;
endpackage

// File: rtl/t1ya_sf_det.sv
module t1ya_sf_det
   import t1ya_pkg::*;
#(
   parameter int unsigned NUM_CH     = 24,
   parameter int unsigned CH_IDX_W   = 5,
   parameter int unsigned SET_FRAMES = 4800,
   parameter int unsigned REL_FRAMES = 1600
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                en_i,
   input  logic                ch_valid_i,
   input  logic [CH_IDX_W-1:0] ch_idx_i,
   input  logic [BYTE_W-1:0]   ch_byte_i,
   input  logic                frm_strobe_i,
   output logic                alarm_o
);
   localparam int unsigned SET_W = $clog2(SET_FRAMES + 1);
   localparam int unsigned REL_W = $clog2(REL_FRAMES + 1);

   logic              clr;
   logic [NUM_CH-1:0] seen_q;
   logic              hit_bad;
   logic              bad_q;
   logic              frame_ok;
   logic [SET_W-1:0]  set_cnt_q;
   logic [REL_W-1:0]  rel_cnt_q;
   logic              alarm_q;

   assign clr     = rst_i || !en_i;
   assign hit_bad = ch_valid_i && (32'(ch_idx_i) < NUM_CH) && ch_byte_i[ALARM_BIT];

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_seen
         logic hit;
         assign hit = ch_valid_i && (32'(ch_idx_i) == c);
         always_ff @(posedge clk_i) begin
            if (clr)               seen_q[c] <= 1'b0;
            else if (frm_strobe_i) seen_q[c] <= hit;
            else if (hit)          seen_q[c] <= 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (clr)               bad_q <= 1'b0;
      else if (frm_strobe_i) bad_q <= hit_bad;
      else if (hit_bad)      bad_q <= 1'b1;
   end

   assign frame_ok = (&seen_q) && !bad_q;

   always_ff @(posedge clk_i) begin
      if (clr) begin
         set_cnt_q <= '0;
         rel_cnt_q <= '0;
         alarm_q   <= 1'b0;
      end else if (frm_strobe_i) begin
         if (!alarm_q) begin
            rel_cnt_q <= '0;
            if (!frame_ok) begin
               set_cnt_q <= '0;
            end else if (32'(set_cnt_q) == SET_FRAMES - 1) begin
               set_cnt_q <= '0;
               alarm_q   <= 1'b1;
            end else begin
               set_cnt_q <= set_cnt_q + 1'b1;
            end
         end else begin
            set_cnt_q <= '0;
            if (frame_ok) begin
               rel_cnt_q <= '0;
            end else if (32'(rel_cnt_q) == REL_FRAMES - 1) begin
               rel_cnt_q <= '0;
               alarm_q   <= 1'b0;
            end else begin
               rel_cnt_q <= rel_cnt_q + 1'b1;
            end
         end
      end
   end

   assign alarm_o = alarm_q;

   // R3: the flag can only rise at a frame close
   a_r3_rise_at_strobe : assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(alarm_q) |-> $past(frm_strobe_i));
   // R5: the flag can only fall at a frame close or when the detector is parked
   a_r5_fall_at_strobe : assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(alarm_q) |-> ($past(frm_strobe_i) || $past(!en_i)));
   // R4: set count stays inside its window
   a_r4_set_bound : assert property (@(posedge clk_i) disable iff (rst_i)
      32'(set_cnt_q) < SET_FRAMES);
   // R5: release count stays inside its window and is idle without an alarm
   a_r5_rel_idle : assert property (@(posedge clk_i) disable iff (rst_i)
      (32'(rel_cnt_q) < REL_FRAMES) && (!alarm_q -> rel_cnt_q == '0));
endmodule

// File: rtl/t1ya_esf_det.sv
module t1ya_esf_det
   import t1ya_pkg::*;
#(
   parameter int unsigned       PAT_W   = CODE_W,
   parameter logic [PAT_W-1:0]  PATTERN = CODE_WORD
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic fdl_valid_i,
   input  logic fdl_bit_i,
   output logic alarm_o
);
   localparam int unsigned FILL_W = $clog2(PAT_W + 1);

   logic              clr;
   logic [PAT_W-1:0]  shr_q;
   logic [PAT_W-1:0]  shr_nx;
   logic [FILL_W-1:0] fill_q;
   logic              full_nx;
   logic              alarm_q;

   assign clr     = rst_i || !en_i;
   assign shr_nx  = {shr_q[PAT_W-2:0], fdl_bit_i};
   assign full_nx = (32'(fill_q) >= PAT_W - 1);

   always_ff @(posedge clk_i) begin
      if (clr) begin
         shr_q   <= '0;
         fill_q  <= '0;
         alarm_q <= 1'b0;
      end else if (fdl_valid_i) begin
         shr_q   <= shr_nx;
         if (32'(fill_q) < PAT_W) fill_q <= fill_q + 1'b1;
         alarm_q <= full_nx && (shr_nx == PATTERN);
      end
   end

   assign alarm_o = alarm_q;

   // R8: no valid bit, no change
   a_r8_hold_idle : assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(fdl_valid_i) && $past(en_i)) |-> $stable(alarm_q));
   // R7: an active flag always matches a full window holding the code word
   a_r7_flag_has_code : assert property (@(posedge clk_i) disable iff (rst_i)
      alarm_q |-> ((shr_q == PATTERN) && (32'(fill_q) == PAT_W)));
endmodule

// File: rtl/t1_yellow_det.sv
module t1_yellow_det
   import t1ya_pkg::*;
#(
   parameter int unsigned NUM_CH     = 24,
   parameter int unsigned CH_IDX_W   = 5,
   parameter int unsigned SET_FRAMES = 4800,
   parameter int unsigned REL_FRAMES = 1600
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                mode_i,
   input  logic                ch_valid_i,
   input  logic [CH_IDX_W-1:0] ch_idx_i,
   input  logic [7:0]          ch_byte_i,
   input  logic                frm_strobe_i,
   input  logic                fdl_valid_i,
   input  logic                fdl_bit_i,
   output logic                alarm_o
);
   generate
      if (NUM_CH < 1 || (1 << CH_IDX_W) < NUM_CH) begin : g_bad_ch
         $error("channel count does not fit the index width");
      end
      if (SET_FRAMES < 1 || REL_FRAMES < 1) begin : g_bad_tmr
         $error("frame thresholds must be at least one");
      end
   endgenerate

   logic sf_en;
   logic esf_en;
   logic sf_alarm;
   logic esf_alarm;

   assign sf_en  = (rule_e'(mode_i) == RULE_SF);
   assign esf_en = (rule_e'(mode_i) == RULE_ESF);

   t1ya_sf_det #(
      .NUM_CH     (NUM_CH),
      .CH_IDX_W   (CH_IDX_W),
      .SET_FRAMES (SET_FRAMES),
      .REL_FRAMES (REL_FRAMES)
   ) sf_i (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .en_i         (sf_en),
      .ch_valid_i   (ch_valid_i),
      .ch_idx_i     (ch_idx_i),
      .ch_byte_i    (ch_byte_i),
      .frm_strobe_i (frm_strobe_i),
      .alarm_o      (sf_alarm)
   );

   t1ya_esf_det #(
      .PAT_W   (CODE_W),
      .PATTERN (CODE_WORD)
   ) esf_i (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .en_i        (esf_en),
      .fdl_valid_i (fdl_valid_i),
      .fdl_bit_i   (fdl_bit_i),
      .alarm_o     (esf_alarm)
   );

   assign alarm_o = esf_en ? esf_alarm : sf_alarm;

   // R9, R10: a parked detector stays quiet
   a_r10_sf_parked : assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(mode_i) && mode_i) |-> !sf_alarm);
   a_r10_esf_parked : assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(mode_i) && !mode_i) |-> !esf_alarm);
   // R1: output low right after reset
   a_r1_reset_low : assert property (@(posedge clk_i)
      $past(rst_i) |-> !alarm_o);
endmodule

// File: tb/t1_yellow_det_tb.sv
module t1_yellow_det_tb_top;
   localparam int unsigned NCH = 24;
   localparam int unsigned SETF = 6;
   localparam int unsigned RELF = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       mode = 1'b0;
   logic       ch_valid = 1'b0;
   logic [4:0] ch_idx = '0;
   logic [7:0] ch_byte = '0;
   logic       frm_strobe = 1'b0;
   logic       fdl_valid = 1'b0;
   logic       fdl_bit = 1'b0;
   logic       alarm;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   t1_yellow_det #(
      .NUM_CH(NCH), .CH_IDX_W(5), .SET_FRAMES(SETF), .REL_FRAMES(RELF)
   ) dut_i (
      .clk_i(clk), .rst_i(rst), .mode_i(mode), .ch_valid_i(ch_valid),
      .ch_idx_i(ch_idx), .ch_byte_i(ch_byte), .frm_strobe_i(frm_strobe),
      .fdl_valid_i(fdl_valid), .fdl_bit_i(fdl_bit), .alarm_o(alarm)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   // kind: 0 clean, 1 one channel with bit 6 set, 2 one channel missing,
   //       3 clean plus out-of-range indices carrying bit 6
   task automatic send_frame(input int kind);
      for (int c = 0; c < NCH; c++) begin
         if (!(kind == 2 && c == 7)) begin
            @(negedge clk);
            ch_valid = 1'b1;
            ch_idx   = 5'(c);
            ch_byte  = (kind == 1 && c == 13) ? 8'h40 : 8'hBF;
         end
      end
      if (kind == 3) begin
         for (int c = NCH; c < 32; c++) begin
            @(negedge clk);
            ch_valid = 1'b1;
            ch_idx   = 5'(c);
            ch_byte  = 8'hFF;
         end
      end
      @(negedge clk);
      ch_valid   = 1'b0;
      frm_strobe = 1'b1;
      @(negedge clk);
      frm_strobe = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      fdl_valid = 1'b1;
      fdl_bit   = b;
      @(negedge clk);
      fdl_valid = 1'b0;
   endtask

   task automatic send_word(input logic [15:0] w);
      for (int i = 15; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic t_reset();
      do_reset();
      chk(alarm, 1'b0, "R1 alarm after reset");
   endtask

   task automatic t_sf_set();
      do_reset();
      mode = 1'b0;
      for (int f = 0; f < SETF - 1; f++) send_frame(f == 2 ? 3 : 0);
      chk(alarm, 1'b0, "R3 one frame short of set");
      send_frame(3);
      chk(alarm, 1'b1, "R3 R2 set after threshold, high indices ignored");
   endtask

   task automatic t_sf_release();
      // alarm is up on entry
      send_frame(1);
      send_frame(1);
      send_frame(0);
      send_frame(1);
      send_frame(1);
      chk(alarm, 1'b1, "R5 scattered bad frames keep alarm");
      send_frame(1);
      chk(alarm, 1'b0, "R5 release after run of bad frames");
   endtask

   task automatic t_sf_restart();
      do_reset();
      for (int f = 0; f < SETF - 2; f++) send_frame(0);
      send_frame(1);
      for (int f = 0; f < SETF - 1; f++) send_frame(0);
      chk(alarm, 1'b0, "R4 R2 set count restarted by bad bit");
      send_frame(0);
      chk(alarm, 1'b1, "R4 set after fresh run");
   endtask

   task automatic t_sf_missing();
      do_reset();
      for (int f = 0; f < SETF - 1; f++) send_frame(0);
      send_frame(2);
      chk(alarm, 1'b0, "R6 missing channel frame not counted");
      for (int f = 0; f < SETF - 1; f++) send_frame(0);
      chk(alarm, 1'b0, "R6 missing channel restarted count");
   endtask

   task automatic t_esf();
      do_reset();
      mode = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 8; i++) send_bit(1'b1);
      chk(alarm, 1'b0, "R7 ones right after clear do not match");
      do_reset();
      for (int i = 15; i >= 1; i--) send_bit(i >= 8 ? 1'b0 : 1'b1);
      chk(alarm, 1'b0, "R7 fifteen bits of code word");
      send_bit(1'b1);
      chk(alarm, 1'b1, "R7 code word detected");
      repeat (10) @(negedge clk);
      chk(alarm, 1'b1, "R8 holds while idle");
      send_bit(1'b1);
      chk(alarm, 1'b0, "R8 drops on breaking bit");
      send_word(16'h08FF);
      chk(alarm, 1'b0, "R7 single error blocks match");
      send_word(16'h00FF);
      chk(alarm, 1'b1, "R7 match after error");
   endtask

   task automatic t_mode();
      // ESF alarm is up on entry
      @(negedge clk);
      mode = 1'b0;
      #1;
      chk(alarm, 1'b0, "R9 switch to mode 0 clears output");
      send_word(16'h00FF);
      chk(alarm, 1'b0, "R10 link bits ignored in mode 0");
      for (int f = 0; f < SETF; f++) send_frame(0);
      chk(alarm, 1'b1, "R9 mode 0 detector starts clean");
      @(negedge clk);
      mode = 1'b1;
      #1;
      chk(alarm, 1'b0, "R9 switch to mode 1 shows cleared detector");
      for (int f = 0; f < SETF; f++) send_frame(0);
      chk(alarm, 1'b0, "R10 channel bytes ignored in mode 1");
      @(negedge clk);
      mode = 1'b0;
      #1;
      chk(alarm, 1'b0, "R9 mode 0 alarm was cleared by switch");
   endtask

   initial begin
      t_reset();
      t_sf_set();
      t_sf_release();
      t_sf_restart();
      t_sf_missing();
      t_esf();
      t_mode();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule